// File: doc/BRIEF.md
# Hash Message Padding Unit

This block sits in front of a 64-byte-block compression core for MD5 or SHA-1. It receives the message as a stream of bytes and packs them little-endian into 32-bit words. At the end of the message it adds the standard padding: a 0x80 marker byte, enough zero words to reach word 14 of a block, and a 64-bit count of the message bits. The result is a valid/ready word stream with a flag on the final word, so the core can tell where each message ends.

A start pulse opens a message and samples the mode input. Optionally, the same pulse loads a byte count restored from an earlier partial context. That count is truncated to a whole number of 64-byte blocks, and any tail bytes it held are sent again through the byte port. The message ends either with a last-flagged byte or with a finish beat that carries no byte. The finish beat is how an empty message, or a message whose bytes are all behind a restored count, is closed. Back-pressure from the core stalls the unit without losing words.

Top module: `msg_padder`

## Requirements
- R1: Each accepted byte is stored little-endian: the first byte of a word goes to bits 7:0 and the fourth to bits 31:24. A word is emitted once it holds four bytes, and words leave in arrival order. Each accepted byte adds one to the byte count.
- R2: If the message ends inside a word, that word is emitted with its unused upper bytes at zero and 0x80 in the byte position directly after the last message byte. If the message ends on a word boundary, a separate word 0x00000080 follows.
- R3: With N the total byte count, fill = 64 − (N mod 64). The minimum is 8 when the marker shares a word with data and 12 when it does not. If fill is below the minimum, 64 is added to fill. Exactly (fill − minimum)/4 zero words follow the marker word.
- R4: The bit length L = 8·N is sent as two words after the zero words. With i_sha1=0 (MD5), the first word is L[31:0] and the second is L[63:32]. With i_sha1=1 (SHA-1), the first word is L[63:32] byte-reversed and the second is L[31:0] byte-reversed.
- R5: o_last is high only on the second length word. Counted from the start pulse, each message emits a multiple of 16 words, and nothing is emitted after the last word until the next start.
- R6: While o_valid is high and o_ready is low, o_valid, o_word and o_last stay unchanged, and no word is dropped or repeated.
- R7: A start pulse with i_restore low sets the byte count to zero. With i_restore high, the count becomes i_restore_cnt with its low six bits cleared.
- R8: A message closed by a finish beat with no bytes gives exactly one block: 0x00000080, thirteen zero words, and two zero length words.
- R9: i_ready is low before the first start, and from the end of a message until the next start. The byte count does not change in that interval.
- R10: The mode is sampled on the start pulse. Changing i_sha1 during the message does not change how the length is encoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_start | input | 1 | Opens a new message; takes priority over all other inputs |
| i_sha1 | input | 1 | Mode sampled at start: 1 = SHA-1 length order, 0 = MD5 |
| i_restore | input | 1 | With i_start, load the restored count instead of zero |
| i_restore_cnt | input | CNT_W | Restored byte count; low six bits are ignored |
| i_valid | input | 1 | A message byte is offered |
| i_byte | input | 8 | Message byte |
| i_last | input | 1 | The offered byte is the final byte of the message |
| i_fin | input | 1 | Ends the message without a byte; only used when i_valid is low |
| i_ready | output | 1 | A byte or finish beat is taken this cycle |
| o_valid | output | 1 | o_word holds a word for the core |
| o_word | output | 32 | Padded message word |
| o_last | output | 1 | Final word of the message |
| o_ready | input | 1 | Core takes the word |

## Verification
Message lengths are chosen to land the marker at each offset within a word and at each side of the 56-byte threshold: 0, 3, 4, 55, 56, 59, 60, 63 and 64. These lengths separate the shared-marker case from the separate-marker case, and the no-spill case from the spill case. Each is run in both modes, so any swap of length halves or bytes shows up. Restored counts with non-zero low bits check the truncation and the upper length bits. Endings by finish beat after a partial word check the marker merge on that path. Random pacing on both handshakes, a forced stall and a mid-message mode change check that words are held, that none are lost, and that the mode is latched at start.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 2;
  localparam int LEN_W  = 64;
  localparam logic [7:0] MARK_BYTE = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_MARK, ST_ZERO, ST_LEN_A, ST_LEN_B
  } pad_state_e;

  // insert a byte at lane position (little-endian packing)
  function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                 input logic [LANE_W-1:0] lane,
                                                 input logic [7:0] b);
    return w | ({{(WORD_W-8){1'b0}}, b} << {lane, 3'b000});
  endfunction

  // unused upper lanes are already zero; OR the marker into the first free lane
  function automatic logic [WORD_W-1:0] marker_word(input logic [WORD_W-1:0] w,
                                                    input logic [LANE_W-1:0] lane);
    return put_byte(w, lane, MARK_BYTE);
  endfunction

  // zero words between marker word and length, from count bits [5:2]
  function automatic logic [3:0] zero_words(input logic [3:0] blk_word);
    return 4'd13 - blk_word;
  endfunction

  function automatic logic [WORD_W-1:0] bswap(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [WORD_W-1:0] len_word(input logic sha1,
                                                 input logic [LEN_W-1:0] bits,
                                                 input logic second);
    if (sha1) return second ? bswap(bits[31:0]) : bswap(bits[63:32]);
    else      return second ? bits[63:32] : bits[31:0];
  endfunction
endpackage

// File: rtl/pad_packer.sv
module pad_packer
  import pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [7:0]        byte_in,
  output logic [WORD_W-1:0] nxt_word,
  output logic [LANE_W:0]   nxt_lane
);
  logic [WORD_W-1:0] acc_q;
  logic [LANE_W-1:0] lane_q;

  assign nxt_word = push ? put_byte(acc_q, lane_q, byte_in) : acc_q;
  assign nxt_lane = {1'b0, lane_q} + {{LANE_W{1'b0}}, push};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (clr || (push && nxt_lane[LANE_W])) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (push) begin
      acc_q  <= nxt_word;
      lane_q <= nxt_lane[LANE_W-1:0];
    end
  end

  // R1: a fourth byte empties the accumulator for the next word
  p_lane_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr && lane_q == 2'd3) |=> (lane_q == 2'd0 && acc_q == '0));
endmodule

// File: rtl/pad_counter.sv
module pad_counter #(
  parameter int CNT_W = 61
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic [3:0]       nxt_blk_word
);
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt      = cnt_q + {{(CNT_W-1){1'b0}}, inc};
  assign nxt_blk_word = cnt_nxt[5:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else           cnt_q <= cnt_nxt;
  end

  // R1: each counted byte advances the total by exactly one
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/msg_padder.sv
module msg_padder
  import pad_pkg::*;
#(
  parameter int CNT_W = 61
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_start,
  input  logic             i_sha1,
  input  logic             i_restore,
  input  logic [CNT_W-1:0] i_restore_cnt,
  input  logic             i_valid,
  input  logic [7:0]       i_byte,
  input  logic             i_last,
  input  logic             i_fin,
  output logic             i_ready,
  output logic             o_valid,
  output logic [31:0]      o_word,
  output logic             o_last,
  input  logic             o_ready
);
  localparam logic [CNT_W-1:0] BLK_MASK = ~CNT_W'(63);

  pad_state_e        st_q, st_d;
  logic [3:0]        zl_q, zl_d;
  logic              sha1_q;
  logic              adv, byte_acc, end_acc;
  logic [WORD_W-1:0] nxt_word, ld_word;
  logic [LANE_W:0]   nxt_lane;
  logic              ld, ld_last;
  logic [CNT_W-1:0]  cnt_q, load_val;
  logic [3:0]        nxt_blk_word;
  logic [LEN_W-1:0]  bits;
  logic [3:0]        wcnt_q;

  // named handshake events
  assign adv      = !o_valid || o_ready;
  assign i_ready  = (st_q == ST_DATA) && adv;
  assign byte_acc = i_ready && i_valid && !i_start;
  assign end_acc  = i_ready && !i_start && (i_valid ? i_last : i_fin);
  assign load_val = i_restore ? (i_restore_cnt & BLK_MASK) : '0;
  assign bits     = {{(LEN_W-CNT_W){1'b0}}, cnt_q} << 3;

  pad_packer u_packer (
    .clk(clk), .rst_n(rst_n), .clr(i_start | end_acc), .push(byte_acc),
    .byte_in(i_byte), .nxt_word(nxt_word), .nxt_lane(nxt_lane)
  );

  pad_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(i_start), .load_val(load_val),
    .inc(byte_acc), .cnt_q(cnt_q), .nxt_blk_word(nxt_blk_word)
  );

  always_comb begin
    st_d    = st_q;
    zl_d    = zl_q;
    ld      = 1'b0;
    ld_word = '0;
    ld_last = 1'b0;
    case (st_q)
      ST_DATA: begin
        if (byte_acc && nxt_lane[LANE_W]) begin
          ld      = 1'b1;
          ld_word = nxt_word;
        end
        if (end_acc) begin
          zl_d = zero_words(nxt_blk_word);
          if (nxt_lane[LANE_W]) begin
            st_d = ST_MARK;
          end else begin
            ld      = 1'b1;
            ld_word = marker_word(nxt_word, nxt_lane[LANE_W-1:0]);
            st_d    = (zl_d == 4'd0) ? ST_LEN_A : ST_ZERO;
          end
        end
      end
      ST_MARK: if (adv) begin
        ld      = 1'b1;
        ld_word = {{(WORD_W-8){1'b0}}, MARK_BYTE};
        st_d    = (zl_q == 4'd0) ? ST_LEN_A : ST_ZERO;
      end
      ST_ZERO: if (adv) begin
        ld   = 1'b1;
        zl_d = zl_q - 4'd1;
        if (zl_q == 4'd1) st_d = ST_LEN_A;
      end
      ST_LEN_A: if (adv) begin
        ld      = 1'b1;
        ld_word = len_word(sha1_q, bits, 1'b0);
        st_d    = ST_LEN_B;
      end
      ST_LEN_B: if (adv) begin
        ld      = 1'b1;
        ld_word = len_word(sha1_q, bits, 1'b1);
        ld_last = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      zl_q    <= '0;
      sha1_q  <= 1'b0;
      o_valid <= 1'b0;
      o_word  <= '0;
      o_last  <= 1'b0;
    end else if (i_start) begin
      st_q    <= ST_DATA;
      zl_q    <= '0;
      sha1_q  <= i_sha1;
      o_valid <= 1'b0;
      o_last  <= 1'b0;
    end else begin
      st_q <= st_d;
      zl_q <= zl_d;
      if (ld) begin
        o_valid <= 1'b1;
        o_word  <= ld_word;
        o_last  <= ld_last;
      end else if (o_ready) begin
        o_valid <= 1'b0;
      end
    end
  end

  // words taken since start, for the block-alignment check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wcnt_q <= '0;
    else if (i_start)            wcnt_q <= '0;
    else if (o_valid && o_ready) wcnt_q <= wcnt_q + 4'd1;
  end

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready && !i_start) |=>
      (o_valid && $stable(o_word) && $stable(o_last)));

  p_last_block_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_last) |-> (wcnt_q == 4'd15));

  p_restore_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    i_start |=> (cnt_q[5:0] == 6'd0));

  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_start && !i_restore) |=> (cnt_q == '0));

  p_count_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_DATA && !i_start) |=> $stable(cnt_q));
endmodule

// File: tb/test_msg_padder.sv
module test_msg_padder;
  localparam int CNT_W = 61;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             i_start = 1'b0, i_sha1 = 1'b0, i_restore = 1'b0;
  logic [CNT_W-1:0] i_restore_cnt = '0;
  logic             i_valid = 1'b0, i_last = 1'b0, i_fin = 1'b0;
  logic [7:0]       i_byte = '0;
  logic             i_ready, o_valid, o_last;
  logic [31:0]      o_word;
  logic             o_ready = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  msg_padder #(.CNT_W(CNT_W)) i_msg_padder (
    .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_sha1(i_sha1),
    .i_restore(i_restore), .i_restore_cnt(i_restore_cnt), .i_valid(i_valid),
    .i_byte(i_byte), .i_last(i_last), .i_fin(i_fin), .i_ready(i_ready),
    .o_valid(o_valid), .o_word(o_word), .o_last(o_last), .o_ready(o_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // padding rule restated through fill/minimum arithmetic
  function automatic int zeros_by_fill(input logic [63:0] total);
    int fill, mn;
    fill = 64 - int'(total % 64);
    mn   = ((total % 4) != 0) ? 8 : 12;
    if (fill < mn) fill += 64;
    return (fill - mn) / 4;
  endfunction

  task automatic run_msg(input int len, input bit sha1, input bit rest,
                         input logic [63:0] rval, input bit use_fin,
                         input int vprob, input int rprob, input bit stall,
                         input bit flip, input string tag_ovr);
    byte unsigned msg[$];
    byte unsigned pb[$];
    logic [63:0]  total, bitsv;
    logic [31:0]  w0;
    int           nexp, idx, got, cyc, zcnt;
    bit           ended, leak, stalled;
    for (int k = 0; k < len; k++) msg.push_back(8'($urandom));
    total = (rest ? (rval & ~64'h3F) : 64'd0) + 64'(len);
    pb = msg;
    pb.push_back(8'h80);
    zcnt = 0;
    while ((pb.size() % 64) != 56) begin pb.push_back(8'h00); zcnt++; end
    bitsv = total << 3;
    for (int k = 0; k < 8; k++)
      pb.push_back(sha1 ? bitsv[8*(7-k) +: 8] : bitsv[8*k +: 8]);
    nexp = pb.size() / 4;
    exp_q.delete();
    tag_q.delete();
    for (int k = 0; k < nexp; k++) begin
      exp_q.push_back({pb[4*k+3], pb[4*k+2], pb[4*k+1], pb[4*k]});
      if (tag_ovr != "")       tag_q.push_back(tag_ovr);
      else if (4*k + 3 < len)  tag_q.push_back("R1");
      else if (4*k <= len)     tag_q.push_back("R2");
      else if (k >= nexp - 2)  tag_q.push_back("R4");
      else                     tag_q.push_back("R3");
    end
    // R3: zero bytes between marker word and length match the fill formula
    chk((zcnt / 4) + ((len % 4 != 0) ? 0 : 0) == zeros_by_fill(total) ||
        (len % 4 == 0 && (zcnt - 3) / 4 == zeros_by_fill(total)),
        "R3", 64'(zcnt), 64'(zeros_by_fill(total)));

    @(negedge clk);
    i_start = 1'b1; i_sha1 = sha1; i_restore = rest;
    i_restore_cnt = rval[CNT_W-1:0];
    i_valid = 1'b0; i_fin = 1'b0; i_last = 1'b0; o_ready = 1'b0;
    @(negedge clk);
    i_start = 1'b0;
    if (flip) i_sha1 = ~sha1;
    idx = 0; got = 0; cyc = 0; ended = 1'b0; leak = 1'b0; stalled = 1'b0;
    while (got < nexp) begin
      if (cyc > 20000) begin
        chk(1'b0, "R6 stream stalled", 64'(got), 64'(nexp));
        break;
      end
      cyc++;
      if (stall && !stalled && o_valid) begin
        stalled = 1'b1;
        o_ready = 1'b0; i_valid = 1'b0; i_fin = 1'b0; i_last = 1'b0;
        w0 = o_word;
        for (int s = 0; s < 4; s++) begin
          @(negedge clk);
          chk(o_valid && o_word == w0, "R6", {31'd0, o_valid, o_word}, {32'd1, w0});
        end
      end
      o_ready = (($urandom % 100) < rprob);
      i_valid = 1'b0; i_fin = 1'b0; i_last = 1'b0;
      if (!ended) begin
        if (idx < len) begin
          if (($urandom % 100) < vprob) begin
            i_valid = 1'b1;
            i_byte  = msg[idx];
            i_last  = (idx == len - 1) && !use_fin;
          end
        end else begin
          i_fin = 1'b1;
        end
      end
      #1;
      if (ended && i_ready) leak = 1'b1;
      if (i_valid && i_ready) begin
        idx++;
        if (i_last) ended = 1'b1;
      end else if (i_fin && i_ready) begin
        ended = 1'b1;
      end
      if (o_valid && o_ready) begin
        chk(o_word == exp_q[got], tag_q[got], 64'(o_word), 64'(exp_q[got]));
        chk(o_last == (got == nexp - 1), "R5", 64'(o_last), 64'(got == nexp - 1));
        got++;
      end
      @(negedge clk);
    end
    i_valid = 1'b0; i_fin = 1'b0; i_last = 1'b0; o_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!leak && !i_ready, "R9", 64'(leak | i_ready), 64'd0);
    chk(!o_valid, "R5", 64'(o_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    summary();
  end

  initial begin
    int lens[9];
    void'($urandom(32'd20240611));
    lens = '{3, 4, 7, 55, 56, 59, 60, 63, 64};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: idle after reset
    chk(!o_valid && !i_ready, "R9", {62'd0, o_valid, i_ready}, 64'd0);

    // R8: empty message, both modes
    run_msg(0, 1'b0, 1'b0, 64'd0, 1'b1, 100, 100, 1'b0, 1'b0, "R8");
    run_msg(0, 1'b1, 1'b0, 64'd0, 1'b1, 100, 100, 1'b0, 1'b0, "R8");
    // boundary lengths in both modes
    foreach (lens[k]) begin
      run_msg(lens[k], 1'b0, 1'b0, 64'd0, 1'b0, 100, 100, 1'b0, 1'b0, "");
      run_msg(lens[k], 1'b1, 1'b0, 64'd0, 1'b0, 70, 60, 1'b0, 1'b0, "");
    end
    // R2: finish beat after a partial word
    run_msg(7, 1'b1, 1'b0, 64'd0, 1'b1, 100, 100, 1'b0, 1'b0, "");
    // R7: restored count with low bits set, then a plain start clears it
    run_msg(21, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b0, 100, 100, 1'b0, 1'b0, "R7");
    run_msg(0, 1'b0, 1'b1, 64'h0000_0000_0000_00FF, 1'b1, 100, 100, 1'b0, 1'b0, "R7");
    run_msg(5, 1'b0, 1'b0, 64'd0, 1'b0, 100, 100, 1'b0, 1'b0, "R7");
    // R6: forced stall
    run_msg(30, 1'b0, 1'b0, 64'd0, 1'b0, 100, 100, 1'b1, 1'b0, "");
    // R10: mode changes after start
    run_msg(40, 1'b1, 1'b0, 64'd0, 1'b0, 100, 100, 1'b0, 1'b1, "R10");
    run_msg(40, 1'b0, 1'b1, 64'h0000_00AB_CDEF_0040, 1'b0, 100, 100, 1'b0, 1'b1, "R10");
    // constrained random
    for (int n = 0; n < 40; n++) begin
      run_msg(int'($urandom % 150), 1'($urandom % 2), ($urandom % 3) == 0,
              {$urandom, $urandom} & 64'h0FFF_FFFF_FFFF_FFFF,
              ($urandom % 4) == 0, 30 + int'($urandom % 71),
              30 + int'($urandom % 71), ($urandom % 5) == 0, ($urandom % 6) == 0, "");
    end
    summary();
  end
endmodule